// File: doc/BRIEF.md
# Power-Control Pin Interpreter

This block turns a single active-low control pin into the enables that gate a clock generator's outputs, its PLLs, its output divider counters and its reference oscillator. A two-bit configuration value selects what a low level on the pin means. It can tri-state every output while the PLLs keep running. It can shut the whole generator down. It can suspend a chosen group of outputs and PLLs. It can also leave the pin with no effect at all.

In suspend mode, two mask vectors name the outputs and the PLLs to stop. The block enforces a dependency rule. An output whose selected source is a stopped PLL is stopped as well, even if its own mask bit is clear. When the configuration contains such a mismatch, a sticky flag records it.

When the pin leaves shutdown, the PLLs need time to relock. A countdown timer, clocked by the reference, keeps the PLL-fed outputs tri-stated and their dividers halted until it expires. Outputs fed directly from the reference resume at once.

Top module: `pwrpin_ctrl`

## Requirements
- R1: With the pin high after reset, every output is driven (out_hiz all 0), every divider and PLL is enabled, osc_en is 1 and conflict is 0.
- R2: The pin passes through a two-flop synchronizer reset to the inactive (high) level. A pin change made between two rising edges first affects the outputs after the second of the following rising edges.
- R3: With mode_cfg = 2'b00 and the synchronized pin low, every out_hiz bit is 1 while all pll_en bits, all div_en bits and osc_en stay 1.
- R4: With mode_cfg = 2'b01 and the synchronized pin low, every out_hiz bit is 1 and all div_en bits, all pll_en bits and osc_en are 0.
- R5: The relock window starts at the first clock edge at which shutdown is no longer active, and lasts relock_len cycles. During it, outputs whose source code is non-zero have out_hiz 1 and div_en 0. Outputs with source code 0 (reference) are driven, and all PLLs and the oscillator are enabled. A relock_len of 0 gives no window.
- R6: With mode_cfg = 2'b10 and the synchronized pin low, pll_en[p] is the inverse of pll_mask[p]. An output with out_mask bit 1 has out_hiz 1 and div_en 0.
- R7: In suspend, an output whose source code k (1..N_PLL selects PLL k-1, 0 selects the reference; field i sits at bits i*SRC_W upward in out_src) names a PLL with pll_mask set is tri-stated with its divider halted, whatever its own mask bit.
- R8: conflict becomes 1 one clock edge after mode_cfg = 2'b10 is seen together with an output whose mask is clear and whose source PLL is masked. The pin level plays no part in this. The flag then stays 1 until reset, even after the configuration is corrected.
- R9: With mode_cfg = 2'b11 the pin level has no effect on any output.
- R10: With the synchronized pin high, no mode stops any output, divider, PLL or the oscillator, apart from the R5 relock window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also clocks the relock timer |
| rst | input | 1 | Synchronous active-high reset |
| ctl_pin_n | input | 1 | Asynchronous active-low control pin |
| mode_cfg | input | 2 | Pin meaning: 00 output enable, 01 shutdown, 10 suspend, 11 ignored |
| out_src | input | N_OUT*SRC_W | Per-output source code, 0 reference, k PLL k-1 |
| out_mask | input | N_OUT | Outputs to stop in suspend (1 = stop) |
| pll_mask | input | N_PLL | PLLs to stop in suspend (1 = stop) |
| relock_len | input | RELOCK_W | Relock wait length in reference cycles |
| out_hiz | output | N_OUT | 1 = output tri-stated |
| div_en | output | N_OUT | Output divider counter enable |
| pll_en | output | N_PLL | PLL enable |
| osc_en | output | 1 | Reference oscillator enable |
| conflict | output | 1 | Sticky flag for a suspend-mask dependency mismatch |

## Verification
The bench targets the cycle at which the synchronized pin takes effect. A design with one synchronizer stage too few or too many would move every response by a cycle. It also covers the relock window, including its first and last cycle and a zero-length setting. An off-by-one there would release PLL-fed outputs early, keep them held too long, or wrongly hold the reference-fed output. Suspend runs with a masked PLL feeding an unmasked output, which a design without the dependency rule would leave driven. The run then clears that configuration to show that the conflict flag is not a live status. Output-enable and ignored modes are run with the pin low, and there a design that confused the modes would drop PLLs or tri-state outputs.

// File: rtl/pwrpin_pkg.sv
package pwrpin_pkg;

    typedef enum logic [1:0] {
        PM_OE   = 2'b00,
        PM_SHUT = 2'b01,
        PM_SUSP = 2'b10,
        PM_FREE = 2'b11
    } pin_mode_e;

    // which power action the synchronized pin currently requests
    typedef struct packed {
        logic oe;
        logic shut;
        logic susp;
    } pin_act_t;

    function automatic pin_act_t decode_pin(logic [1:0] mode, logic pin_low);
        pin_act_t a;
        a.oe   = pin_low && (mode == PM_OE);
        a.shut = pin_low && (mode == PM_SHUT);
        a.susp = pin_low && (mode == PM_SUSP);
        return a;
    endfunction

endpackage

// File: rtl/pwrpin_sync.sv
module pwrpin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic pin_low
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], pin_n};
    end

    assign pin_low = ~chain[STAGES-1];
endmodule

// File: rtl/pwrpin_relock.sv
module pwrpin_relock #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         busy
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= len;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    // R5: window counts down by one per cycle once shutdown has ended
    assert_relock_step_R5: assert property (@(posedge clk) disable iff (rst)
        (!load && busy) |=> (cnt == $past(cnt) - 1'b1));

    // R5: the window length is taken from the programmed value
    assert_relock_load_R5: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(len)));
endmodule

// File: rtl/pwrpin_route.sv
module pwrpin_route
    import pwrpin_pkg::*;
#(
    parameter int N_OUT = 3,
    parameter int N_PLL = 3,
    parameter int SRC_W = 2
) (
    input  pin_act_t               act,
    input  logic                   susp_cfg,
    input  logic                   busy,
    input  logic [N_OUT*SRC_W-1:0] out_src,
    input  logic [N_OUT-1:0]       out_mask,
    input  logic [N_PLL-1:0]       pll_mask,
    output logic [N_OUT-1:0]       out_hiz,
    output logic [N_OUT-1:0]       div_en,
    output logic [N_PLL-1:0]       pll_en,
    output logic                   cfg_conflict
);
    logic [N_OUT-1:0] forced;

    generate
        for (genvar p = 0; p < N_PLL; p++) begin : g_pll
            assign pll_en[p] = ~(act.shut | (act.susp & pll_mask[p]));
        end

        for (genvar i = 0; i < N_OUT; i++) begin : g_out
            logic [SRC_W-1:0] sel;
            logic             from_pll;
            logic             src_masked;
            logic             stop;
            logic             hold;

            assign sel      = out_src[i*SRC_W +: SRC_W];
            assign from_pll = (sel != '0) && (int'(sel) <= N_PLL);

            always_comb begin
                src_masked = 1'b0;
                for (int p = 0; p < N_PLL; p++) begin
                    if (from_pll && (int'(sel) == p + 1)) src_masked = pll_mask[p];
                end
            end

            assign stop      = act.susp & (out_mask[i] | src_masked);
            assign hold      = busy & from_pll;
            assign forced[i] = susp_cfg & src_masked & ~out_mask[i];
            assign out_hiz[i] = act.oe | act.shut | stop | hold;
            assign div_en[i]  = ~(act.shut | stop | hold);
        end
    endgenerate

    assign cfg_conflict = |forced;
endmodule

// File: rtl/pwrpin_ctrl.sv
module pwrpin_ctrl
    import pwrpin_pkg::*;
#(
    parameter int N_OUT    = 3,
    parameter int N_PLL    = 3,
    parameter int RELOCK_W = 16,
    localparam int SRC_W   = $clog2(N_PLL + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ctl_pin_n,
    input  logic [1:0]             mode_cfg,
    input  logic [N_OUT*SRC_W-1:0] out_src,
    input  logic [N_OUT-1:0]       out_mask,
    input  logic [N_PLL-1:0]       pll_mask,
    input  logic [RELOCK_W-1:0]    relock_len,
    output logic [N_OUT-1:0]       out_hiz,
    output logic [N_OUT-1:0]       div_en,
    output logic [N_PLL-1:0]       pll_en,
    output logic                   osc_en,
    output logic                   conflict
);
    logic     pin_low;
    pin_act_t act;
    logic     busy;
    logic     cfg_conflict;

    pwrpin_sync #(.STAGES(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pin_n   (ctl_pin_n),
        .pin_low (pin_low)
    );

    assign act = decode_pin(mode_cfg, pin_low);

    pwrpin_relock #(.W(RELOCK_W)) u_relock (
        .clk  (clk),
        .rst  (rst),
        .load (act.shut),
        .len  (relock_len),
        .busy (busy)
    );

    pwrpin_route #(.N_OUT(N_OUT), .N_PLL(N_PLL), .SRC_W(SRC_W)) u_route (
        .act          (act),
        .susp_cfg     (mode_cfg == PM_SUSP),
        .busy         (busy),
        .out_src      (out_src),
        .out_mask     (out_mask),
        .pll_mask     (pll_mask),
        .out_hiz      (out_hiz),
        .div_en       (div_en),
        .pll_en       (pll_en),
        .cfg_conflict (cfg_conflict)
    );

    assign osc_en = ~act.shut;

    always_ff @(posedge clk) begin
        if (rst)               conflict <= 1'b0;
        else if (cfg_conflict) conflict <= 1'b1;
    end

    // R8: once raised the flag only clears through reset
    assert_conflict_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        conflict |=> conflict);

    // R4: shutdown stops oscillator, every PLL and every divider
    assert_shutdown_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (pin_low && mode_cfg == PM_SHUT) |-> (!osc_en && pll_en == '0 && div_en == '0));

    // R3: output-enable mode never stops a PLL or the oscillator
    assert_oe_keeps_plls_R3: assert property (@(posedge clk) disable iff (rst)
        (mode_cfg == PM_OE) |-> (&pll_en && osc_en));

    // R9: ignored mode with no relock pending drives everything
    assert_free_mode_R9: assert property (@(posedge clk) disable iff (rst)
        (mode_cfg == PM_FREE && !busy) |-> (out_hiz == '0 && &pll_en && &div_en));

    generate
        for (genvar i = 0; i < N_OUT; i++) begin : g_chk
            logic [SRC_W-1:0] s;
            assign s = out_src[i*SRC_W +: SRC_W];
            // R7: no output is driven from a stopped PLL
            assert_no_orphan_R7: assert property (@(posedge clk) disable iff (rst)
                ((s != '0) && (int'(s) <= N_PLL) && !pll_en[int'(s) - 1]) |-> out_hiz[i]);
        end
    endgenerate
endmodule

// File: tb/pwrpin_ctrl_tb.sv
module pwrpin_ctrl_tb;
    localparam int N_OUT = 3;
    localparam int N_PLL = 3;
    localparam int RW    = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pin_n = 1'b1;
    logic [1:0] mode = 2'b00;
    logic [1:0] src [N_OUT];
    logic [N_OUT-1:0] omask = '0;
    logic [N_PLL-1:0] pmask = '0;
    logic [RW-1:0] rlen = 16'd5;
    logic [N_OUT*2-1:0] out_src;
    logic [N_OUT-1:0] out_hiz, div_en;
    logic [N_PLL-1:0] pll_en;
    logic osc_en, conflict;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    assign out_src = {src[2], src[1], src[0]};

    always #5 clk = ~clk;

    pwrpin_ctrl #(.N_OUT(N_OUT), .N_PLL(N_PLL), .RELOCK_W(RW)) u_dut (
        .clk(clk), .rst(rst), .ctl_pin_n(pin_n), .mode_cfg(mode),
        .out_src(out_src), .out_mask(omask), .pll_mask(pmask), .relock_len(rlen),
        .out_hiz(out_hiz), .div_en(div_en), .pll_en(pll_en),
        .osc_en(osc_en), .conflict(conflict)
    );

    // behavioural reference state
    logic m_s1 = 1'b1, m_s2 = 1'b1;
    int   m_cnt = 0;
    bit   m_conf = 0;

    function automatic bit cfg_mismatch();
        for (int i = 0; i < N_OUT; i++)
            if (src[i] != 0 && pmask[src[i]-1] && !omask[i]) return 1;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s1 = 1'b1; m_s2 = 1'b1; m_cnt = 0; m_conf = 0;
        end else begin
            if (mode == 2'b01 && !m_s2) m_cnt = int'(rlen);
            else if (m_cnt > 0)         m_cnt = m_cnt - 1;
            if (mode == 2'b10 && cfg_mismatch()) m_conf = 1;
            m_s2 = m_s1;
            m_s1 = pin_n;
        end
    end

    // every-cycle comparison with the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit low, shut, oe, sus, pm, stop, hold;
            logic [N_OUT-1:0] e_hiz, e_div;
            logic [N_PLL-1:0] e_pll;
            string tag;
            low  = !m_s2;
            shut = low && mode == 2'b01;
            oe   = low && mode == 2'b00;
            sus  = low && mode == 2'b10;
            for (int i = 0; i < N_OUT; i++) begin
                pm   = src[i] != 0 && pmask[src[i]-1];
                stop = sus && (omask[i] || pm);
                hold = m_cnt > 0 && src[i] != 0;
                e_hiz[i] = oe || shut || stop || hold;
                e_div[i] = !(shut || stop || hold);
            end
            for (int p = 0; p < N_PLL; p++) e_pll[p] = !(shut || (sus && pmask[p]));
            if (m_cnt > 0)           tag = "R5";
            else if (!low)           tag = "R10";
            else if (mode == 2'b00)  tag = "R3";
            else if (mode == 2'b01)  tag = "R4";
            else if (mode == 2'b10)  tag = "R6";
            else                     tag = "R9";
            checks++;
            if (out_hiz !== e_hiz || div_en !== e_div || pll_en !== e_pll ||
                osc_en !== !shut || conflict !== m_conf) begin
                fails++;
                $display("FAIL %s t=%0t actual hiz=%b div=%b pll=%b osc=%b cf=%b expected hiz=%b div=%b pll=%b osc=%b cf=%b",
                         tag, $time, out_hiz, div_en, pll_en, osc_en, conflict,
                         e_hiz, e_div, e_pll, !shut, m_conf);
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        src[0] = 2'd1; src[1] = 2'd2; src[2] = 2'd0;
        step(3);
        rst = 1'b0;
        step(2);
        @(negedge clk);
        chk("R1 hiz", out_hiz, 0); chk("R1 pll", pll_en, 3'b111);
        chk("R1 div", div_en, 3'b111); chk("R1 osc", osc_en, 1); chk("R1 conflict", conflict, 0);

        // R2 and R3: pin low in output-enable mode
        step(0); pin_n = 1'b0;
        step(1); @(negedge clk); chk("R2 one edge", out_hiz, 0);
        step(1); @(negedge clk); chk("R2 two edges", out_hiz, 3'b111);
        chk("R3 pll run", pll_en, 3'b111); chk("R3 div run", div_en, 3'b111);
        step(3); pin_n = 1'b1; step(4);

        // R4 and R5: shutdown then relock
        mode = 2'b01; rlen = 16'd5; pin_n = 1'b0;
        step(2); @(negedge clk);
        chk("R4 osc", osc_en, 0); chk("R4 pll", pll_en, 0); chk("R4 div", div_en, 0);
        step(3); pin_n = 1'b1;
        step(2); @(negedge clk);
        chk("R5 ref resumes", out_hiz, 3'b011); chk("R5 plls on", pll_en, 3'b111);
        step(4); @(negedge clk); chk("R5 last held", out_hiz, 3'b011);
        step(1); @(negedge clk); chk("R5 released", out_hiz, 0);

        // R5 zero-length window
        rlen = 16'd0; pin_n = 1'b0; step(4); pin_n = 1'b1;
        step(2); @(negedge clk); chk("R5 zero window", out_hiz, 0);
        step(2);

        // R6: suspend with consistent masks
        mode = 2'b10; omask = 3'b001; pmask = 3'b001; pin_n = 1'b0;
        step(2); @(negedge clk);
        chk("R6 hiz", out_hiz, 3'b001); chk("R6 pll", pll_en, 3'b110);
        chk("R8 no conflict", conflict, 0);
        // R7: masked PLL2 forces unmasked output 1
        step(0); pmask = 3'b011;
        step(1); @(negedge clk);
        chk("R7 forced", out_hiz, 3'b011); chk("R7 div", div_en, 3'b100);
        chk("R8 raised", conflict, 1);
        // R7: reroute output 2 onto masked PLL3
        step(0); src[2] = 2'd3; pmask = 3'b100; omask = 3'b000;
        step(1); @(negedge clk); chk("R7 reroute", out_hiz, 3'b100);
        // R8: corrected configuration leaves flag set
        step(0); pmask = 3'b000; pin_n = 1'b1; step(4);
        @(negedge clk); chk("R8 sticky", conflict, 1); chk("R10 suspend idle", out_hiz, 0);

        // R9: ignored mode
        mode = 2'b11; pin_n = 1'b0; step(4); @(negedge clk);
        chk("R9 hiz", out_hiz, 0); chk("R9 pll", pll_en, 3'b111);
        pin_n = 1'b1; step(3);

        // R10: pin high in shutdown mode
        mode = 2'b01; step(4); @(negedge clk);
        chk("R10 osc", osc_en, 1); chk("R10 div", div_en, 3'b111);

        // R8 reset clears flag
        rst = 1'b1; step(2); rst = 1'b0; step(1); @(negedge clk);
        chk("R8 reset clears", conflict, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule